// File: doc/BRIEF.md
# Status Byte and Write-Protect Arbiter

This block keeps the status byte of a serial EEPROM-style memory and rules on every write that the command decoder wants to start. The byte carries a write-enable latch, a two-bit protection level that fences off a quarter, a half or all of the array, and a protect-enable bit that lets an active-low protect pin lock the status byte. The command decoder hands the block one-cycle strobes: set the enable latch, clear it, or request a status write with its data byte. The block answers a status write with a one-cycle go pulse when it is allowed. It also answers, for the address currently presented, whether an array write there may start.

The self-timed write cycle runs outside the block and is reported back on `busy`. A status write that was allowed is held as pending and lands in the status byte when `busy` falls. The enable latch clears at the end of every write cycle, whether it was an array or a status write. The protect bits are modelled as ordinary flops that update only at that moment. While a cycle runs, and in the one cycle after it, the byte reads as all ones and every command strobe is dropped.

Top module: `srProtect`

## Requirements
- R1: After reset the status byte reads 0x00 and `writePermit` and `statWrGo` are low.
- R2: When the block is idle, a set strobe makes bit 1 of the status byte read 1 from the next cycle. A clear strobe makes it read 0 from the next cycle, whatever the level of `wpN`. If both strobes come in the same cycle, the clear wins.
- R3: The block is idle when `busy` is low in this cycle and was low in the previous one. Whenever it is not idle, `statusOut` reads 0xFF and all three command strobes are ignored.
- R4: `statWrGo` pulses in the same cycle as a status write request exactly when the block is idle, bit 1 is 1, and hardware protection is off. Hardware protection is on when `wpN` is 0 and bit 7 is 1.
- R5: An accepted status write copies data bits 7, 3 and 2 into status bits 7, 3 and 2. The new value and a cleared bit 1 are visible once the block is idle again after the next fall of `busy`. Data bits 6 to 4, 1 and 0 have no effect.
- R6: Every fall of `busy` clears bit 1, including cycles that carried no status write.
- R7: A change on `wpN` after a status write was accepted does not stop it from landing.
- R8: Status bits 3:2 select the protected range by the two top address bits: 00 none, 01 top bits 11, 10 top bit 1, 11 everything. `writePermit` is 1 exactly when the block is idle, bit 1 is 1, and the address is outside that range. Hardware protection does not affect it.
- R9: With `wpN` low and bit 7 set, a status write that would clear bit 7 is refused, and bit 7 stays 1.
- R10: When the block is idle, status bits 6 to 4 and bit 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setWenReq | input | 1 | Strobe: set the write-enable latch |
| clrWenReq | input | 1 | Strobe: clear the write-enable latch |
| statWrReq | input | 1 | Strobe: status write request, data on statWrData |
| statWrData | input | 8 | Byte offered to the status register |
| wpN | input | 1 | Protect pin, active low |
| busy | input | 1 | High while the self-timed write cycle runs |
| queryAddr | input | ADDR_W | Array address to rule on |
| statusOut | output | 8 | Status byte as read by the host |
| statWrGo | output | 1 | Status write accepted, start the timed cycle |
| writePermit | output | 1 | Array write at queryAddr may start |

## Verification
A wrong enable latch or a wrong protection level shows in `statusOut` and `writePermit` in the cycle after the stimulus. The bench compares both outputs on every cycle, so the error is caught at once. A pending status write that is captured wrongly or lost stays hidden until the block is idle again after `busy` falls, and that is where the bench samples it. A faulty idle window shows as a status byte that is not 0xFF, or as a strobe that takes effect during the cycle after the fall.

// File: rtl/srp_pkg.sv
package srp_pkg;
  // Bit positions of the status byte; the host decodes them.
  localparam int unsigned BIT_PEN  = 7;
  localparam int unsigned BIT_LVH  = 3;
  localparam int unsigned BIT_LVL  = 2;
  localparam int unsigned BIT_WEN  = 1;
  localparam int unsigned BIT_BUSY = 0;

  // Strobes from control to datapath.
  typedef struct packed {
    logic setWen;
    logic clrWen;
    logic loadPend;
    logic commit;
  } srStrobes_t;

  // Protection levels, indexed by status bits 3:2.
  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } protLevel_t;
endpackage

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSetWen,
  input  logic       reqClrWen,
  input  logic       reqStatWr,
  input  logic       busy,
  input  logic       wpN,
  input  logic       wenNow,
  input  logic       penNow,
  output srStrobes_t stb,
  output logic       idle,
  output logic       statWrGo
);
  logic busyQ;
  logic pendValid;
  logic busyFell;
  logic hwLock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      busyQ <= busy;
      if (stb.commit)
        pendValid <= 1'b0;
      else if (stb.loadPend)
        pendValid <= 1'b1;
    end
  end

  always_comb begin
    idle       = !busy && !busyQ;
    busyFell   = busyQ && !busy;
    hwLock     = !wpN && penNow;
    statWrGo   = reqStatWr && idle && wenNow && !hwLock;
    stb.setWen   = reqSetWen && idle;
    stb.clrWen   = (reqClrWen && idle) || busyFell;
    stb.loadPend = statWrGo;
    stb.commit   = busyFell && pendValid;
  end
endmodule

// File: rtl/srp_data.sv
module srp_data
  import srp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  srStrobes_t stb,
  input  logic [2:0] newBits,
  input  logic       idle,
  input  logic [1:0] addrTop,
  output logic [7:0] statusOut,
  output logic       writePermit,
  output logic       wenNow,
  output logic       penNow
);
  logic       wen;
  logic       pen;
  protLevel_t level;
  logic [2:0] pendBits;
  logic       inFence;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wen      <= 1'b0;
      pen      <= 1'b0;
      level    <= LVL_NONE;
      pendBits <= 3'b000;
    end else begin
      if (stb.clrWen)
        wen <= 1'b0;
      else if (stb.setWen)
        wen <= 1'b1;
      if (stb.loadPend)
        pendBits <= newBits;
      if (stb.commit) begin
        pen   <= pendBits[2];
        level <= protLevel_t'(pendBits[1:0]);
      end
    end
  end

  always_comb begin
    case (level)
      LVL_NONE:    inFence = 1'b0;
      LVL_QUARTER: inFence = (addrTop == 2'b11);
      LVL_HALF:    inFence = addrTop[1];
      default:     inFence = 1'b1;
    endcase
  end

  always_comb begin
    statusOut           = 8'h00;
    statusOut[BIT_PEN]  = pen;
    statusOut[BIT_LVH]  = level[1];
    statusOut[BIT_LVL]  = level[0];
    statusOut[BIT_WEN]  = wen;
    statusOut[BIT_BUSY] = 1'b0;
    if (!idle)
      statusOut = 8'hFF;
  end

  assign writePermit = idle && wen && !inFence;
  assign wenNow      = wen;
  assign penNow      = pen;
endmodule

// File: rtl/srProtect.sv
module srProtect
  import srp_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              setWenReq,
  input  logic              clrWenReq,
  input  logic              statWrReq,
  input  logic [7:0]        statWrData,
  input  logic              wpN,
  input  logic              busy,
  input  logic [ADDR_W-1:0] queryAddr,
  output logic [7:0]        statusOut,
  output logic              statWrGo,
  output logic              writePermit
);
  localparam int unsigned TOP_LSB = ADDR_W - 2;

  srStrobes_t stb;
  logic       idle;
  logic       wenNow;
  logic       penNow;
  logic [2:0] newBits;
  logic [1:0] addrTop;
  logic       unusedBits;

  assign newBits    = {statWrData[BIT_PEN], statWrData[BIT_LVH], statWrData[BIT_LVL]};
  assign addrTop    = queryAddr[ADDR_W-1:TOP_LSB];
  assign unusedBits = ^{statWrData[6:4], statWrData[1:0], queryAddr[TOP_LSB-1:0]};

  srp_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqSetWen (setWenReq),
    .reqClrWen (clrWenReq),
    .reqStatWr (statWrReq),
    .busy      (busy),
    .wpN       (wpN),
    .wenNow    (wenNow),
    .penNow    (penNow),
    .stb       (stb),
    .idle      (idle),
    .statWrGo  (statWrGo)
  );

  srp_data uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .newBits     (newBits),
    .idle        (idle),
    .addrTop     (addrTop),
    .statusOut   (statusOut),
    .writePermit (writePermit),
    .wenNow      (wenNow),
    .penNow      (penNow)
  );
endmodule

// File: rtl/srProtect_chk.sv
module srProtect_chk #(
  parameter int unsigned ADDR_W = 13
)(
  input logic              clk,
  input logic              rstN,
  input logic              setWenReq,
  input logic              clrWenReq,
  input logic              statWrReq,
  input logic [7:0]        statWrData,
  input logic              wpN,
  input logic              busy,
  input logic [ADDR_W-1:0] queryAddr,
  input logic [7:0]        statusOut,
  input logic              statWrGo,
  input logic              writePermit
);
  logic unusedChk;
  assign unusedChk = ^{setWenReq, clrWenReq, statWrData, queryAddr};

  assert_busy_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statusOut == 8'hFF);

  assert_go_needs_wen_R4: assert property (@(posedge clk) disable iff (!rstN)
    statWrGo |-> (statWrReq && !busy && statusOut[1] && !(!wpN && statusOut[7])));

  assert_fall_clears_wen_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy, 2) && !$past(busy) && !busy) |-> !statusOut[1]);

  assert_permit_rules_R8: assert property (@(posedge clk) disable iff (!rstN)
    writePermit |-> (!busy && statusOut[1] && statusOut[3:2] != 2'b11));

  assert_idle_zero_bits_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> (statusOut[6:4] == 3'b000 && !statusOut[0]));

  assert_pen_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !$past(busy, 2) && $past(statusOut[7]) && !$past(wpN)
      && !$past(busy, 3)) |-> statusOut[7]);
endmodule

bind srProtect srProtect_chk #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_srProtect.sv
module tb_srProtect;
  localparam int unsigned AW = 13;

  logic          clk = 1'b0;
  logic          rstN;
  logic          setWenReq, clrWenReq, statWrReq, wpN, busy;
  logic [7:0]    statWrData;
  logic [AW-1:0] queryAddr;
  logic [7:0]    statusOut;
  logic          statWrGo, writePermit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  bit       mWen, mPen, mPendV, mBusyQ;
  bit [1:0] mLvl;
  bit [2:0] mPend;
  bit       lastGo;

  always #5 clk = ~clk;

  srProtect #(.ADDR_W(AW)) dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit fenced(input bit [1:0] lvl, input bit [AW-1:0] a);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1:AW-2] == 2'b11;
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  // One cycle: drive, compare against the reference, advance the reference.
  task automatic step(input bit sw, input bit cw, input bit stw, input bit [7:0] d,
                      input bit wp, input bit b, input bit [AW-1:0] a);
    bit idle, go, fell;
    bit [7:0] expS;
    @(negedge clk);
    setWenReq = sw; clrWenReq = cw; statWrReq = stw; statWrData = d;
    wpN = wp; busy = b; queryAddr = a;
    #1;
    idle = !b && !mBusyQ;
    expS = idle ? {mPen, 3'b000, mLvl, mWen, 1'b0} : 8'hFF;
    go   = stw && idle && mWen && !(!wp && mPen);
    chk("R3/R10 status", statusOut, expS);
    chk("R4 go", {7'd0, statWrGo}, {7'd0, go});
    chk("R8 permit", {7'd0, writePermit}, {7'd0, idle && mWen && !fenced(mLvl, a)});
    fell = mBusyQ && !b;
    if (fell) begin
      mWen = 1'b0;                         // R6
      if (mPendV) begin
        {mPen, mLvl} = mPend;              // R5
        mPendV = 1'b0;
      end
    end else if (idle) begin
      if (cw) mWen = 1'b0;
      else if (sw) mWen = 1'b1;
    end
    if (go) begin
      mPendV = 1'b1;
      mPend  = {d[7], d[3], d[2]};
    end
    mBusyQ = b;
    lastGo = go;
  endtask

  task automatic idleCyc(input int n, input bit wp, input bit [AW-1:0] a);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, wp, 0, a);
  endtask

  task automatic busyCyc(input int n, input bit wp);
    for (int i = 0; i < n; i++) step(1, 1, 1, 8'h00, wp, 1, '0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int busyLeft;
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; setWenReq = 0; clrWenReq = 0; statWrReq = 0; statWrData = 0;
    wpN = 1; busy = 0; queryAddr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 status", statusOut, 8'h00);
    chk("R1 permit", {7'd0, writePermit}, 8'h00);
    chk("R1 go", {7'd0, statWrGo}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // R2: set latch
    step(1, 0, 0, 8'h00, 1, 0, '0);
    idleCyc(1, 1, '0);
    chk("R2 set", statusOut, 8'h02);
    // R4/R5: status write pen=1 level=01, junk bits set
    step(0, 0, 1, 8'hF7, 1, 0, '0);
    chk("R4 accept", {7'd0, lastGo}, 8'h01);
    // R7: pin toggles low during the timed cycle
    step(0, 0, 0, 8'h00, 0, 1, '0);
    busyCyc(2, 0);
    step(0, 0, 0, 8'h00, 1, 0, '0);
    idleCyc(1, 1, '0);
    chk("R5 R7 committed", statusOut, 8'h84);
    // R8: quarter fence with hardware lock active
    step(1, 0, 0, 8'h00, 0, 0, '0);
    step(0, 0, 0, 8'h00, 0, 0, 13'h17FF);
    chk("R8 below fence", {7'd0, writePermit}, 8'h01);
    step(0, 0, 0, 8'h00, 0, 0, 13'h1800);
    chk("R8 in fence", {7'd0, writePermit}, 8'h00);
    // R9: cannot clear pen while pin low
    step(0, 0, 1, 8'h00, 0, 0, '0);
    chk("R9 refused", {7'd0, lastGo}, 8'h00);
    idleCyc(1, 0, '0);
    chk("R9 pen held", statusOut, 8'h86);
    // R2: clear works with pin low; clear beats set
    step(1, 1, 0, 8'h00, 0, 0, '0);
    idleCyc(1, 0, '0);
    chk("R2 clear", statusOut, 8'h84);
    // R6: array cycle end clears latch
    step(1, 0, 0, 8'h00, 1, 0, '0);
    busyCyc(3, 1);
    idleCyc(2, 1, '0);
    chk("R6 clear on fall", statusOut, 8'h84);

    // Random phase
    busyLeft = 0;
    for (int i = 0; i < 4000; i++) begin
      bit sw, cw, stw, wp, b;
      bit [7:0] d;
      bit [AW-1:0] a;
      if (lastGo) busyLeft = 2 + int'($urandom % 4);
      else if (busyLeft == 0 && !mBusyQ && ($urandom % 40) == 0) busyLeft = 1 + int'($urandom % 5);
      b   = busyLeft > 0;
      sw  = ($urandom % 4) == 0;
      cw  = ($urandom % 12) == 0;
      stw = ($urandom % 5) == 0;
      wp  = ($urandom % 3) != 0;
      d   = 8'($urandom);
      a   = AW'($urandom);
      step(sw, cw, stw, d, wp, b, a);
      if (busyLeft > 0) busyLeft--;
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule